// File: doc/BRIEF.md
# Cascaded Display Stream Splitter

This block sits at the input of one controller board in a chain of boards that together drive a display too large for any single board. A byte stream enters with a frame-start flag on its first byte. The block sends every byte on to the next board one cycle later, unchanged and without ever stalling. It also groups the bytes into pixels of three bytes each and counts them. The pixels whose index falls inside this board's region go out as writes to the local frame buffer.

Each board learns its share from a board index input. Board `k` owns the `PIX_PER_BOARD` consecutive pixels that start at `k * PIX_PER_BOARD`. The default region is 4096 pixels, which is four 32x32 modules. The write address is the pixel index relative to the start of the region. Every board in the chain receives the same stream, so boards can be added without changing the neighbours.

Top module: `cascade_stream_splitter`

## Requirements
- R1: Every cycle, `out_valid`, `out_sof` and `out_data` equal the `in_valid`, `in_sof` and `in_data` of the previous cycle. The block applies no backpressure and never drops or reorders a byte.
- R2: Cycles with `in_valid` low carry no byte. They do not advance the pixel assembly and cause no write, so idle gaps inside a pixel do not change its value.
- R3: A pixel is three consecutive valid bytes in the order red, green, blue. On its write, `wr_rgb[23:16]` holds red, `wr_rgb[15:8]` holds green and `wr_rgb[7:0]` holds blue.
- R4: A valid byte with `in_sof` high is the red byte of pixel 0. It restarts both the byte position and the pixel count, even if it arrives in the middle of a pixel, and the partial pixel is discarded.
- R5: A completed pixel with index `i` produces `wr_en` high for exactly one cycle, in the cycle after its blue byte. This happens only when `board_idx*PIX_PER_BOARD <= i < (board_idx+1)*PIX_PER_BOARD`, and then `wr_addr = i - board_idx*PIX_PER_BOARD`.
- R6: A frame that ends before this board's first pixel produces no write and has no other visible effect.
- R7: The pixel count stops at `PIX_PER_BOARD*MAX_BOARDS`. Pixels beyond that count never write, including on board 0, until the next frame start. After the next frame start, writes resume normally.
- R8: While `rst` is high, and in the cycle after it, `out_valid` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_sof | input | 1 | Input byte is the first byte of a frame |
| in_data | input | BYTE_W | Input byte |
| board_idx | input | $clog2(MAX_BOARDS) | Position of this board in the chain |
| out_valid | output | 1 | Forwarded byte present |
| out_sof | output | 1 | Forwarded frame-start flag |
| out_data | output | BYTE_W | Forwarded byte |
| wr_en | output | 1 | Frame buffer write strobe |
| wr_addr | output | $clog2(PIX_PER_BOARD) | Local frame buffer address |
| wr_rgb | output | 3*BYTE_W | Pixel colour, red in the top byte |

## Verification
The hardest case to reach is the wrap of the pixel count past the largest frame. At the default sizes it needs tens of thousands of pixels, and if the count wrapped, board 0 would see its own pixels again. The bench therefore shrinks the region and the board count through parameters and sends an oversized frame to board 0. It then checks that no write appears after the last legal pixel, and that writes come back after a new frame start. A frame-start flag in the middle of a pixel and idle gaps inside pixels are driven as directed cases. Random frames then vary the board index, the frame length and the gap density.

// File: rtl/cas_split_pkg.sv
package cas_split_pkg;
  localparam int BYTE_W_DEF = 8;
  localparam int BYTES_PER_PIX = 3;

  typedef struct packed {
    logic [BYTE_W_DEF-1:0] red;
    logic [BYTE_W_DEF-1:0] green;
    logic [BYTE_W_DEF-1:0] blue;
  } rgb_pix_t;
endpackage

// File: rtl/cas_fwd_stage.sv
module cas_fwd_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         i_valid,
  input  logic         i_sof,
  input  logic [W-1:0] i_data,
  output logic         o_valid,
  output logic         o_sof,
  output logic [W-1:0] o_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_sof   <= 1'b0;
      o_data  <= '0;
    end else begin
      o_valid <= i_valid;
      o_sof   <= i_sof & i_valid;
      o_data  <= i_data;
    end
  end
endmodule

// File: rtl/cas_pix_assembler.sv
module cas_pix_assembler #(
  parameter int BW  = 8,
  parameter int BPP = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             i_valid,
  input  logic             i_sof,
  input  logic [BW-1:0]    i_data,
  output logic             pix_fire,
  output logic [BPP*BW-1:0] pix_word
);
  localparam int LANE_W = (BPP > 1) ? $clog2(BPP) : 1;
  localparam int HOLD_W = (BPP - 1) * BW;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(BPP - 1);

  logic [LANE_W-1:0] lane_q;
  logic [LANE_W-1:0] lane_eff;
  logic [HOLD_W-1:0] hold_q;
  logic [BPP*BW-1:0] shifted;

  assign lane_eff = i_sof ? '0 : lane_q;
  assign pix_fire = i_valid && (lane_eff == LAST_LANE);
  assign shifted  = {hold_q, i_data};
  assign pix_word = shifted;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q <= '0;
      hold_q <= '0;
    end else if (i_valid) begin
      lane_q <= pix_fire ? '0 : lane_eff + LANE_W'(1);
      hold_q <= shifted[HOLD_W-1:0];
    end
  end
endmodule

// File: rtl/cas_region_filter.sv
module cas_region_filter #(
  parameter int PIX_PER_BOARD = 4096,
  parameter int MAX_BOARDS    = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             i_valid,
  input  logic                             i_sof,
  input  logic                             pix_fire,
  input  logic [$clog2(MAX_BOARDS)-1:0]    board_idx,
  output logic                             hit,
  output logic [$clog2(PIX_PER_BOARD)-1:0] local_addr
);
  localparam int MAX_PIX = PIX_PER_BOARD * MAX_BOARDS;
  localparam int LOC_W   = $clog2(PIX_PER_BOARD);
  localparam int IDX_W   = $clog2(MAX_BOARDS);
  localparam int CNT_W   = $clog2(MAX_PIX) + 1;
  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(MAX_PIX);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_eff;
  logic             in_frame;
  logic             region_match;

  assign cnt_eff      = (i_valid && i_sof) ? '0 : cnt_q;
  assign in_frame     = cnt_eff < CNT_CAP;
  assign region_match = cnt_eff[CNT_W-1:LOC_W] == {1'b0, board_idx};
  assign hit          = pix_fire && in_frame && region_match;
  assign local_addr   = cnt_eff[LOC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (i_valid) begin
      if (pix_fire) cnt_q <= in_frame ? cnt_eff + CNT_W'(1) : CNT_CAP;
      else          cnt_q <= cnt_eff;
    end
  end

  if (IDX_W + LOC_W + 1 != CNT_W) begin : g_size_bad
    initial $error("PIX_PER_BOARD and MAX_BOARDS must be powers of two");
  end
endmodule

// File: rtl/cascade_stream_splitter.sv
module cascade_stream_splitter #(
  parameter int BYTE_W        = 8,
  parameter int PIX_PER_BOARD = 4096,
  parameter int MAX_BOARDS    = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             in_valid,
  input  logic                             in_sof,
  input  logic [BYTE_W-1:0]                in_data,
  input  logic [$clog2(MAX_BOARDS)-1:0]    board_idx,
  output logic                             out_valid,
  output logic                             out_sof,
  output logic [BYTE_W-1:0]                out_data,
  output logic                             wr_en,
  output logic [$clog2(PIX_PER_BOARD)-1:0] wr_addr,
  output logic [3*BYTE_W-1:0]              wr_rgb
);
  import cas_split_pkg::*;
  localparam int LOC_W = $clog2(PIX_PER_BOARD);
  localparam int PIX_W = BYTES_PER_PIX * BYTE_W;

  logic             pix_fire;
  logic [PIX_W-1:0] pix_word;
  logic             hit;
  logic [LOC_W-1:0] local_addr;

  cas_fwd_stage #(.W(BYTE_W)) u_fwd (
    .clk(clk), .rst(rst),
    .i_valid(in_valid), .i_sof(in_sof), .i_data(in_data),
    .o_valid(out_valid), .o_sof(out_sof), .o_data(out_data)
  );

  cas_pix_assembler #(.BW(BYTE_W), .BPP(BYTES_PER_PIX)) u_asm (
    .clk(clk), .rst(rst),
    .i_valid(in_valid), .i_sof(in_sof), .i_data(in_data),
    .pix_fire(pix_fire), .pix_word(pix_word)
  );

  cas_region_filter #(.PIX_PER_BOARD(PIX_PER_BOARD), .MAX_BOARDS(MAX_BOARDS)) u_rgn (
    .clk(clk), .rst(rst),
    .i_valid(in_valid), .i_sof(in_sof), .pix_fire(pix_fire),
    .board_idx(board_idx), .hit(hit), .local_addr(local_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_rgb  <= '0;
    end else begin
      wr_en <= hit;
      if (hit) begin
        wr_addr <= local_addr;
        wr_rgb  <= pix_word;
      end
    end
  end
endmodule

// File: rtl/cas_splitter_chk.sv
module cas_splitter_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_sof,
  input logic [BW-1:0] in_data,
  input logic          out_valid,
  input logic          out_sof,
  input logic [BW-1:0] out_data,
  input logic          wr_en
);
  logic armed = 1'b0;
  logic seen  = 1'b0;
  always_ff @(posedge clk) begin
    armed <= !rst;
    seen  <= 1'b1;
  end

  AST_FWD_VALID: assert property (@(posedge clk) disable iff (rst)
    armed |-> out_valid == $past(in_valid)); // R1
  AST_FWD_DATA: assert property (@(posedge clk) disable iff (rst)
    armed && out_valid |-> out_data == $past(in_data) && out_sof == $past(in_sof)); // R1
  AST_WR_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
    armed && wr_en |-> $past(in_valid)); // R2
  AST_WR_SPACED: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en); // R3
  AST_NO_WR_ON_SOF: assert property (@(posedge clk) disable iff (rst)
    armed && $past(in_valid && in_sof) |-> !wr_en); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    seen && $past(rst) |-> !out_valid && !wr_en); // R8
endmodule

bind cascade_stream_splitter cas_splitter_chk #(.BW(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
  .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data), .wr_en(wr_en)
);

// File: tb/tb_cascade_stream_splitter.sv
module tb_cascade_stream_splitter;
  localparam int P    = 64;
  localparam int NB   = 4;
  localparam int MAXP = P * NB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] board_idx = '0;
  logic out_valid, out_sof, wr_en;
  logic [7:0] out_data;
  logic [5:0] wr_addr;
  logic [23:0] wr_rgb;

  always #10 clk = ~clk;

  cascade_stream_splitter #(.BYTE_W(8), .PIX_PER_BOARD(P), .MAX_BOARDS(NB)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .board_idx(board_idx), .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_rgb(wr_rgb)
  );

  int checks = 0, errors = 0, wr_seen = 0;
  int m_lane = 0, m_pix = 0;
  logic [7:0] m_r = '0, m_g = '0;
  string cur_req = "R5";
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit s, logic [7:0] d);
    bit exp_wr = 0;
    int exp_addr = 0;
    logic [23:0] exp_rgb = '0;
    in_valid = v; in_sof = s; in_data = d;
    if (v) begin
      if (s) begin m_lane = 0; m_pix = 0; end
      case (m_lane)
        0: m_r = d;
        1: m_g = d;
        default: begin
          exp_wr = (m_pix < MAXP) && (m_pix / P == int'(board_idx));
          exp_addr = m_pix % P;
          exp_rgb = {m_r, m_g, d};
          if (m_pix < MAXP) m_pix++;
        end
      endcase
      m_lane = (m_lane + 1) % 3;
    end
    @(posedge clk); @(negedge clk);
    chk(out_valid == v, "R1", "out_valid", int'(out_valid), int'(v));
    if (v) begin
      chk(out_data == d, "R1", "out_data", int'(out_data), int'(d));
      chk(out_sof == s, "R1", "out_sof", int'(out_sof), int'(s));
    end
    chk(wr_en == exp_wr, cur_req, "wr_en", int'(wr_en), int'(exp_wr));
    if (wr_en && exp_wr) begin
      chk(int'(wr_addr) == exp_addr, "R5", "wr_addr", int'(wr_addr), exp_addr);
      chk(wr_rgb == exp_rgb, "R3", "wr_rgb", int'(wr_rgb), int'(exp_rgb));
    end
    if (wr_en) wr_seen++;
  endtask

  task automatic send_frame(int npix, int gap_pct);
    for (int p = 0; p < npix; p++)
      for (int c = 0; c < 3; c++) begin
        while (int'($urandom % 100) < gap_pct) step(0, 0, 8'($urandom));
        step(1, (p == 0) && (c == 0), 8'($urandom));
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int w0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R8", "out_valid in reset", int'(out_valid), 0);
    chk(wr_en == 0, "R8", "wr_en in reset", int'(wr_en), 0);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0 && wr_en == 0, "R8", "outputs after reset", int'({out_valid, wr_en}), 0);

    // R3 R5: full frame, board 1, no gaps
    board_idx = 2'd1; cur_req = "R5"; wr_seen = 0;
    send_frame(MAXP, 0);
    chk(wr_seen == P, "R5", "writes for board 1", wr_seen, P);

    // R2: gaps inside pixels
    board_idx = 2'd2; cur_req = "R2"; wr_seen = 0;
    send_frame(MAXP, 40);
    chk(wr_seen == P, "R2", "writes with gaps", wr_seen, P);

    // R4: frame start in the middle of a pixel
    board_idx = 2'd0; cur_req = "R4"; wr_seen = 0;
    step(1, 1, 8'h11); step(1, 0, 8'h22);
    step(1, 1, 8'hA1); step(1, 0, 8'hB2); step(1, 0, 8'hC3);
    chk(wr_seen == 1, "R4", "single write after restart", wr_seen, 1);
    chk(wr_rgb == 24'hA1B2C3 && wr_addr == 0, "R4", "restart pixel", int'(wr_rgb), 32'hA1B2C3);

    // R6: short frame never reaches board 3
    board_idx = 2'd3; cur_req = "R6"; wr_seen = 0;
    send_frame(100, 10);
    repeat (4) step(0, 0, 8'h00);
    chk(wr_seen == 0, "R6", "writes for short frame", wr_seen, 0);

    // R7: oversized frame on board 0, count must not wrap
    board_idx = 2'd0; cur_req = "R7"; wr_seen = 0;
    send_frame(MAXP, 0);
    w0 = wr_seen;
    chk(w0 == P, "R7", "writes before cap", w0, P);
    for (int p = 0; p < 70; p++)
      for (int c = 0; c < 3; c++) step(1, 0, 8'($urandom));
    chk(wr_seen == w0, "R7", "writes after cap", wr_seen - w0, 0);
    wr_seen = 0;
    send_frame(5, 0);
    chk(wr_seen == 5, "R7", "writes resume after frame start", wr_seen, 5);

    // random frames: R1 R2 R5
    cur_req = "R5";
    for (int f = 0; f < 8; f++) begin
      board_idx = 2'($urandom);
      send_frame(1 + int'($urandom % (MAXP + 20)), int'($urandom % 30));
    end
    repeat (3) step(0, 0, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule